// File: doc/BRIEF.md
# Microcode image loader controller

This controller copies a microcode image from main memory into the on-chip control stores. The image is a list of four-word load records. Each record names a target store, a target address and up to two data words. The controller fetches the four words of a record through a memory read port and decodes the record type. It then drives exactly one write strobe into the instruction memory, the decode map or the register file. After that it moves on to the next record, until it reaches the end record.

Software or a boot sequencer starts the controller with a base pointer and a mode bit. In replacement mode (mode bit 0), tasking stays off for the whole load and the controller finishes by presenting a jump to the start address taken from the end record. In overlay mode (mode bit 1), tasking is briefly re-enabled between records and the controller returns with tasking on, ignoring the start address. Instruction-memory records aimed at the loader's own reserved page are dropped without a write. The controller also compares the end record's checksum against a running sum of the data words it has read.

The memory read port is split in two. The request side is a valid/ready channel: once the controller raises `req_valid`, it holds `req_valid` and `req_addr` unchanged until the cycle in which `req_ready` is high. At most one request is outstanding at any time. The response side has no ready signal. While a request is outstanding, the controller accepts the single `rsp_valid` beat in whatever cycle it arrives. The store write ports and all status pins are plain strobes and levels.

Top module: `ucode_loader`

## Requirements
- R1: A record occupies four consecutive words at p, p+1, p+2 and p+3: a header, a target address, data word 0 and data word 1. The next record starts at p+4. Requests are issued in strictly ascending address order, starting at `base_ptr`.
- R2: While `req_valid` is high and `req_ready` is low, `req_valid` stays high and `req_addr` stays unchanged in the next cycle.
- R3: Header bits [1:0] give the record type: 0 = instruction memory, 1 = decode map, 2 = end, 3 = register file. For a type-0 record, `imem_we` pulses with `imem_addr` = target, `imem_lh` = word 0 and `imem_rh` = word 1. The flags come from the header: bit 15 → `imem_lh_pbad`, bit 14 → `imem_rsel_x`, bit 13 → `imem_rh_pbad`, bit 12 → `imem_block`.
- R4: A type-0 record whose target bits [15:6] equal the reserved page (octal 76, i.e. addresses octal 7600–7677) produces no write, and loading continues with the next record.
- R5: For a type-3 record, `rf_we` pulses with `rf_bank` = target[7:4], `rf_idx` = target[3:0] and `rf_data` = word 0.
- R6: For a type-1 record, `map_we` pulses with `map_brk` = target[7:0], `map_iset` = target[9:8], `map_lh` = word 0 and `map_rh` = word 1. Target bits above bit 9 are ignored.
- R7: Each record produces at most one write strobe, and `task_en` is low in every cycle in which any store write strobe is high.
- R8: After the end record, `done` pulses for one cycle and `busy` falls. `final_ptr` equals the end record's address plus 4. In replacement mode, `jump_valid` pulses together with `done`, `jump_addr` holds end word 1, and `task_en` stays low afterwards.
- R9: In overlay mode, `jump_valid` never rises. `task_en` is high for exactly one cycle after each non-end record while `busy` is high, and it stays high after completion.
- R10: `dec_reset` pulses once after a start is accepted and once after each record, including the end record. For a list of N non-end records, that is N+2 pulses.
- R11: `csum_actual` is the 16-bit wrapping sum of data words 0 and 1 of every non-end record, including skipped ones. `csum_expect` is end word 0. `csum_bad` is high when the two differ. Loading completes either way.
- R12: After reset the controller is idle: `busy`, `done`, `req_valid`, `dec_reset` and all write strobes are low, and `task_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin loading (ignored while busy) |
| base_ptr | input | AW | Address of the first record |
| overlay_mode | input | 1 | 0 = replace and jump, 1 = overlay and return |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | AW | Read word address |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | 16 | Read data |
| imem_we | output | 1 | Instruction memory write strobe |
| imem_addr | output | 16 | Instruction memory address |
| imem_lh | output | 16 | Left half data |
| imem_rh | output | 16 | Right half data |
| imem_lh_pbad | output | 1 | Force bad parity, left half |
| imem_rh_pbad | output | 1 | Force bad parity, right half |
| imem_rsel_x | output | 1 | Extra register-select bit |
| imem_block | output | 1 | Block flag |
| map_we | output | 1 | Decode map write strobe |
| map_iset | output | 2 | Instruction set select |
| map_brk | output | 8 | Breakpoint-instruction field |
| map_lh | output | 16 | Decode map left half |
| map_rh | output | 16 | Decode map right half |
| rf_we | output | 1 | Register file write strobe |
| rf_bank | output | 4 | Register bank |
| rf_idx | output | 4 | Register within bank |
| rf_data | output | 16 | Register value |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle completion pulse |
| jump_valid | output | 1 | Jump to start address (replacement mode) |
| jump_addr | output | 16 | Start address from end record |
| final_ptr | output | AW | Word after the end record |
| task_en | output | 1 | Tasking enable |
| dec_reset | output | 1 | Decode unit reset pulse |
| csum_expect | output | 16 | Checksum from end record |
| csum_actual | output | 16 | Running sum of data words |
| csum_bad | output | 1 | Checksum mismatch |

## Verification
Several properties are checked on every cycle. The request address is held under back-pressure. At most one store strobe is high at a time, and no strobe fires while tasking is enabled. No instruction write ever lands in the reserved page. A jump appears only together with `done`, and never in overlay mode. The bench scenarios cover the rest: that each record's fields reach the right pins, that reserved-page records vanish while their neighbours at octal 7577 and 7700 are written, and that the pulse counts, the final pointer, the checksum verdict and the exit tasking state are correct for lists of several shapes, including a list with only an end record.

// File: rtl/ucl_pkg.sv
package ucl_pkg;
  localparam int WORD_W = 16;
  localparam int REC_WORDS = 4;

  typedef enum logic [1:0] {
    RK_IMEM = 2'd0,
    RK_MAP  = 2'd1,
    RK_END  = 2'd2,
    RK_RF   = 2'd3
  } rec_kind_e;

  typedef enum logic [2:0] {
    T_IDLE, T_ISSUE, T_FETCH, T_EXEC, T_GAP
  } top_state_e;

  typedef enum logic [1:0] {
    R_IDLE, R_REQ, R_WAIT
  } rd_state_e;

  typedef struct packed {
    logic [WORD_W-1:0] hdr;
    logic [WORD_W-1:0] tgt;
    logic [WORD_W-1:0] w0;
    logic [WORD_W-1:0] w1;
  } rec_t;
endpackage

// File: rtl/ucl_reader.sv
module ucl_reader
  import ucl_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch,
  input  logic [AW-1:0]     base,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [AW-1:0]     req_addr,
  input  logic              rsp_valid,
  input  logic [WORD_W-1:0] rsp_data,
  output rec_t              rec,
  output logic              rec_done
);
  localparam int IDX_W = $clog2(REC_WORDS);

  rd_state_e                          st;
  logic [IDX_W-1:0]                   idx;
  logic [AW-1:0]                      base_q;
  logic [REC_WORDS-1:0][WORD_W-1:0]   words;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= R_IDLE;
      idx      <= '0;
      base_q   <= '0;
      words    <= '0;
      rec_done <= 1'b0;
    end else begin
      rec_done <= 1'b0;
      unique case (st)
        R_IDLE: if (fetch) begin
          base_q <= base;
          idx    <= '0;
          st     <= R_REQ;
        end
        R_REQ: if (req_ready) st <= R_WAIT;
        R_WAIT: if (rsp_valid) begin
          words[idx] <= rsp_data;
          if (idx == IDX_W'(REC_WORDS - 1)) begin
            st       <= R_IDLE;
            rec_done <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
            st  <= R_REQ;
          end
        end
        default: st <= R_IDLE;
      endcase
    end
  end

  assign req_valid = (st == R_REQ);
  assign req_addr  = base_q + AW'(idx);
  assign rec.hdr   = words[0];
  assign rec.tgt   = words[1];
  assign rec.w0    = words[2];
  assign rec.w1    = words[3];

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));
endmodule

// File: rtl/ucl_route.sv
module ucl_route
  import ucl_pkg::*;
#(
  parameter int PAGE_LSB  = 6,
  parameter int ISET_W    = 2,
  parameter int RESV_PAGE = 'o76
) (
  input  logic              exec,
  input  rec_t              rec,
  output logic              is_end,
  output logic              imem_we,
  output logic [WORD_W-1:0] imem_addr,
  output logic [WORD_W-1:0] imem_lh,
  output logic [WORD_W-1:0] imem_rh,
  output logic              imem_lh_pbad,
  output logic              imem_rh_pbad,
  output logic              imem_rsel_x,
  output logic              imem_block,
  output logic              map_we,
  output logic [ISET_W-1:0] map_iset,
  output logic [7:0]        map_brk,
  output logic [WORD_W-1:0] map_lh,
  output logic [WORD_W-1:0] map_rh,
  output logic              rf_we,
  output logic [3:0]        rf_bank,
  output logic [3:0]        rf_idx,
  output logic [WORD_W-1:0] rf_data
);
  localparam int PG_W = WORD_W - PAGE_LSB;

  rec_kind_e kind;
  logic      on_resv;
  logic      unused_hdr;

  assign kind       = rec_kind_e'(rec.hdr[1:0]);
  assign on_resv    = (rec.tgt[WORD_W-1:PAGE_LSB] == PG_W'(RESV_PAGE));
  assign unused_hdr = ^rec.hdr[11:2];
  assign is_end     = (kind == RK_END);

  assign imem_we      = exec && (kind == RK_IMEM) && !on_resv;
  assign imem_addr    = rec.tgt;
  assign imem_lh      = rec.w0;
  assign imem_rh      = rec.w1;
  assign imem_lh_pbad = rec.hdr[15];
  assign imem_rsel_x  = rec.hdr[14];
  assign imem_rh_pbad = rec.hdr[13];
  assign imem_block   = rec.hdr[12];

  assign map_we   = exec && (kind == RK_MAP);
  assign map_brk  = rec.tgt[7:0];
  assign map_iset = rec.tgt[8 +: ISET_W];
  assign map_lh   = rec.w0;
  assign map_rh   = rec.w1;

  assign rf_we   = exec && (kind == RK_RF);
  assign rf_bank = rec.tgt[7:4];
  assign rf_idx  = rec.tgt[3:0];
  assign rf_data = rec.w0;
endmodule

// File: rtl/ucl_sum.sv
module ucl_sum
  import ucl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              add,
  input  logic              fin,
  input  logic [WORD_W-1:0] w0,
  input  logic [WORD_W-1:0] w1,
  output logic [WORD_W-1:0] sum_q,
  output logic [WORD_W-1:0] expect_q,
  output logic              bad_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q    <= '0;
      expect_q <= '0;
      bad_q    <= 1'b0;
    end else if (clear) begin
      sum_q    <= '0;
      expect_q <= '0;
      bad_q    <= 1'b0;
    end else if (add) begin
      sum_q <= sum_q + w0 + w1;
    end else if (fin) begin
      expect_q <= w0;
      bad_q    <= (sum_q != w0);
    end
  end
endmodule

// File: rtl/ucode_loader.sv
module ucode_loader
  import ucl_pkg::*;
#(
  parameter int AW        = 16,
  parameter int PAGE_LSB  = 6,
  parameter int RESV_PAGE = 'o76
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base_ptr,
  input  logic          overlay_mode,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  input  logic          rsp_valid,
  input  logic [15:0]   rsp_data,
  output logic          imem_we,
  output logic [15:0]   imem_addr,
  output logic [15:0]   imem_lh,
  output logic [15:0]   imem_rh,
  output logic          imem_lh_pbad,
  output logic          imem_rh_pbad,
  output logic          imem_rsel_x,
  output logic          imem_block,
  output logic          map_we,
  output logic [1:0]    map_iset,
  output logic [7:0]    map_brk,
  output logic [15:0]   map_lh,
  output logic [15:0]   map_rh,
  output logic          rf_we,
  output logic [3:0]    rf_bank,
  output logic [3:0]    rf_idx,
  output logic [15:0]   rf_data,
  output logic          busy,
  output logic          done,
  output logic          jump_valid,
  output logic [15:0]   jump_addr,
  output logic [AW-1:0] final_ptr,
  output logic          task_en,
  output logic          dec_reset,
  output logic [15:0]   csum_expect,
  output logic [15:0]   csum_actual,
  output logic          csum_bad
);
  localparam logic [AW-1:0] STEP = AW'(REC_WORDS);
  localparam int PG_W = WORD_W - PAGE_LSB;

  top_state_e    st;
  logic [AW-1:0] ptr;
  logic          mode_q;
  logic          fetch, rec_done, exec, is_end;
  rec_t          rec;

  assign fetch = (st == T_ISSUE);
  assign exec  = (st == T_EXEC);
  assign busy  = (st != T_IDLE);

  ucl_reader #(.AW(AW)) u_reader (
    .clk(clk), .rst_n(rst_n), .fetch(fetch), .base(ptr),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rec(rec), .rec_done(rec_done)
  );

  ucl_route #(.PAGE_LSB(PAGE_LSB), .ISET_W(2), .RESV_PAGE(RESV_PAGE)) u_route (
    .exec(exec), .rec(rec), .is_end(is_end),
    .imem_we(imem_we), .imem_addr(imem_addr), .imem_lh(imem_lh), .imem_rh(imem_rh),
    .imem_lh_pbad(imem_lh_pbad), .imem_rh_pbad(imem_rh_pbad),
    .imem_rsel_x(imem_rsel_x), .imem_block(imem_block),
    .map_we(map_we), .map_iset(map_iset), .map_brk(map_brk),
    .map_lh(map_lh), .map_rh(map_rh),
    .rf_we(rf_we), .rf_bank(rf_bank), .rf_idx(rf_idx), .rf_data(rf_data)
  );

  ucl_sum u_sum (
    .clk(clk), .rst_n(rst_n),
    .clear(st == T_IDLE && start),
    .add(exec && !is_end),
    .fin(exec && is_end),
    .w0(rec.w0), .w1(rec.w1),
    .sum_q(csum_actual), .expect_q(csum_expect), .bad_q(csum_bad)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= T_IDLE;
      ptr        <= '0;
      mode_q     <= 1'b0;
      task_en    <= 1'b1;
      done       <= 1'b0;
      jump_valid <= 1'b0;
      jump_addr  <= '0;
      final_ptr  <= '0;
      dec_reset  <= 1'b0;
    end else begin
      done       <= 1'b0;
      jump_valid <= 1'b0;
      dec_reset  <= 1'b0;
      unique case (st)
        T_IDLE: if (start) begin
          ptr       <= base_ptr;
          mode_q    <= overlay_mode;
          task_en   <= 1'b0;
          dec_reset <= 1'b1;
          st        <= T_ISSUE;
        end
        T_ISSUE: st <= T_FETCH;
        T_FETCH: if (rec_done) st <= T_EXEC;
        T_EXEC: begin
          dec_reset <= 1'b1;
          ptr       <= ptr + STEP;
          if (is_end) begin
            st         <= T_IDLE;
            done       <= 1'b1;
            jump_valid <= !mode_q;
            jump_addr  <= rec.w1;
            final_ptr  <= ptr + STEP;
            task_en    <= mode_q;
          end else if (mode_q) begin
            task_en <= 1'b1;
            st      <= T_GAP;
          end else begin
            st <= T_ISSUE;
          end
        end
        T_GAP: begin
          task_en <= 1'b0;
          st      <= T_ISSUE;
        end
        default: st <= T_IDLE;
      endcase
    end
  end

  // R7
  store_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({imem_we, map_we, rf_we}));
  // R7
  write_tasks_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (imem_we || map_we || rf_we) |-> !task_en);
  // R4
  resv_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    imem_we |-> (imem_addr[15:PAGE_LSB] != PG_W'(RESV_PAGE)));
  // R8
  jump_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jump_valid |-> (done && !busy));
  // R9
  overlay_no_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_q) |-> !jump_valid);
endmodule

// File: tb/tb_ucode_loader.sv
module tb_ucode_loader;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        start = 1'b0, overlay_mode = 1'b0;
  logic [15:0] base_ptr = '0;
  logic        req_valid, req_ready = 1'b0;
  logic [15:0] req_addr;
  logic        rsp_valid = 1'b0;
  logic [15:0] rsp_data = '0;
  logic        imem_we, imem_lh_pbad, imem_rh_pbad, imem_rsel_x, imem_block;
  logic [15:0] imem_addr, imem_lh, imem_rh;
  logic        map_we;
  logic [1:0]  map_iset;
  logic [7:0]  map_brk;
  logic [15:0] map_lh, map_rh;
  logic        rf_we;
  logic [3:0]  rf_bank, rf_idx;
  logic [15:0] rf_data;
  logic        busy, done, jump_valid, task_en, dec_reset, csum_bad;
  logic [15:0] jump_addr, final_ptr, csum_expect, csum_actual;

  ucode_loader dut (.*);

  // memory model with back-pressure and variable latency
  logic [15:0] mem [0:255];
  logic [7:0]  bp_cnt = '0;
  logic        pend = 1'b0;
  logic [1:0]  dly = '0;
  logic [15:0] pd = '0;
  always @(posedge clk) begin
    bp_cnt    <= bp_cnt + 8'd1;
    req_ready <= (bp_cnt % 8'd3) != 8'd1;
    rsp_valid <= 1'b0;
    if (req_valid && req_ready) begin
      pend <= 1'b1; dly <= bp_cnt[1:0]; pd <= mem[req_addr[7:0]];
    end else if (pend) begin
      if (dly == 2'd0) begin rsp_valid <= 1'b1; rsp_data <= pd; pend <= 1'b0; end
      else dly <= dly - 2'd1;
    end
  end

  int total = 0, bad = 0;
  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // image description
  logic [15:0] r_hdr [0:31], r_tgt [0:31], r_w0 [0:31], r_w1 [0:31];
  int nrec;
  task automatic add_rec(logic [1:0] k, logic [3:0] x, logic [15:0] t, logic [15:0] a, logic [15:0] b);
    r_hdr[nrec] = {x, 1'b0, 9'd0, k};
    r_tgt[nrec] = t; r_w0[nrec] = a; r_w1[nrec] = b;
    nrec++;
  endtask

  // monitor
  logic        mon_on = 1'b0;
  int          lg_n, rq_n, n_dec, n_gap, n_wtask, n_stall_bad, n_jump;
  logic [1:0]  lg_k [0:63];
  logic [15:0] lg_a [0:63], lg_d0 [0:63], lg_d1 [0:63];
  logic [3:0]  lg_f [0:63];
  logic [15:0] rq_a [0:255];
  logic        prev_stall = 1'b0;
  logic [15:0] prev_addr = '0;
  always @(negedge clk) if (mon_on) begin
    if (imem_we) begin
      lg_k[lg_n] = 2'd0; lg_a[lg_n] = imem_addr; lg_d0[lg_n] = imem_lh; lg_d1[lg_n] = imem_rh;
      lg_f[lg_n] = {imem_lh_pbad, imem_rsel_x, imem_rh_pbad, imem_block}; lg_n++;
    end
    if (map_we) begin
      lg_k[lg_n] = 2'd1; lg_a[lg_n] = {6'd0, map_iset, map_brk}; lg_d0[lg_n] = map_lh;
      lg_d1[lg_n] = map_rh; lg_f[lg_n] = 4'd0; lg_n++;
    end
    if (rf_we) begin
      lg_k[lg_n] = 2'd3; lg_a[lg_n] = {8'd0, rf_bank, rf_idx}; lg_d0[lg_n] = rf_data;
      lg_d1[lg_n] = 16'd0; lg_f[lg_n] = 4'd0; lg_n++;
    end
    if ((imem_we || map_we || rf_we) && task_en) n_wtask++;
    if (dec_reset) n_dec++;
    if (task_en && busy) n_gap++;
    if (jump_valid) n_jump++;
    if (prev_stall && !(req_valid && req_addr == prev_addr)) n_stall_bad++;
    prev_stall = req_valid && !req_ready;
    prev_addr  = req_addr;
    if (req_valid && req_ready) begin rq_a[rq_n[7:0]] = req_addr; rq_n++; end
  end

  task automatic run(logic [15:0] base, logic mode, logic good);
    logic [15:0] sum = 16'd0, ck, sa;
    int j = 0, cyc = 0, rqbad = 0;
    for (int i = 0; i < nrec; i++) begin
      sum = sum + r_w0[i] + r_w1[i];
      mem[8'(base + 16'(4*i))]     = r_hdr[i];
      mem[8'(base + 16'(4*i + 1))] = r_tgt[i];
      mem[8'(base + 16'(4*i + 2))] = r_w0[i];
      mem[8'(base + 16'(4*i + 3))] = r_w1[i];
    end
    ck = good ? sum : sum + 16'd1;
    sa = 16'hBEE0 ^ 16'(nrec);
    mem[8'(base + 16'(4*nrec))]     = 16'h0002;
    mem[8'(base + 16'(4*nrec + 1))] = 16'h0000;
    mem[8'(base + 16'(4*nrec + 2))] = ck;
    mem[8'(base + 16'(4*nrec + 3))] = sa;
    @(posedge clk); #1;
    lg_n = 0; rq_n = 0; n_dec = 0; n_gap = 0; n_wtask = 0; n_stall_bad = 0; n_jump = 0;
    mon_on = 1'b1;
    start = 1'b1; base_ptr = base; overlay_mode = mode;
    @(posedge clk); #1; start = 1'b0;
    while (done !== 1'b1 && cyc < 5000) begin @(negedge clk); cyc++; end
    if (done !== 1'b1) begin total++; bad++; $display("FAIL R8 watchdog act=0 exp=1"); end
    chk("R8 final_ptr", final_ptr, base + 16'(4*(nrec+1)));
    chk("R8 R9 jump_valid", jump_valid, !mode);
    if (!mode) chk("R8 jump_addr", jump_addr, sa);
    chk("R11 csum_actual", csum_actual, sum);
    chk("R11 csum_expect", csum_expect, ck);
    chk("R11 csum_bad", csum_bad, !good);
    @(negedge clk);
    chk("R8 done pulse/busy", {done, busy}, 2'b00);
    chk("R8 R9 exit task_en", task_en, mode);
    repeat (2) @(negedge clk);
    mon_on = 1'b0;
    chk("R9 gap cycles", n_gap, mode ? nrec : 0);
    chk("R9 jump count", n_jump, mode ? 0 : 1);
    chk("R10 dec_reset pulses", n_dec, nrec + 2);
    chk("R7 write while tasking", n_wtask, 0);
    chk("R2 stall hold", n_stall_bad, 0);
    chk("R1 request count", rq_n, 4*(nrec+1));
    for (int i = 0; i < rq_n && i < 256; i++) if (rq_a[i] !== base + 16'(i)) rqbad++;
    chk("R1 request order", rqbad, 0);
    for (int i = 0; i < nrec; i++) begin
      logic [1:0] k = r_hdr[i][1:0];
      if (k == 2'd0 && r_tgt[i][15:6] == 10'o76) continue;
      if (j < lg_n) begin
        if (k == 2'd0) begin
          chk("R3 R4 imem write", {lg_k[j], lg_a[j], lg_f[j]}, {k, r_tgt[i], r_hdr[i][15:12]});
          chk("R3 imem data", {lg_d0[j], lg_d1[j]}, {r_w0[i], r_w1[i]});
        end else if (k == 2'd1) begin
          chk("R6 map write", {lg_k[j], lg_a[j]}, {k, 6'd0, r_tgt[i][9:0]});
          chk("R6 map data", {lg_d0[j], lg_d1[j]}, {r_w0[i], r_w1[i]});
        end else begin
          chk("R5 rf write", {lg_k[j], lg_a[j], lg_d0[j]}, {k, 8'd0, r_tgt[i][7:0], r_w0[i]});
        end
      end
      j++;
    end
    chk("R4 R7 write count", lg_n, j);
  endtask

  initial begin
    #(200000 * 10);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 idle", {busy, done, req_valid, dec_reset, imem_we, map_we, rf_we}, 7'd0);
    chk("R12 task_en", task_en, 1'b1);

    // instruction memory sweep: all flag combos plus reserved-page edges
    nrec = 0;
    for (int i = 0; i < 16; i++)
      add_rec(2'd0, 4'(i), 16'h0100 + 16'(i * 'h41), 16'h5A5A ^ 16'(i * 'h1111), 16'(i * 'h0F1D) + 16'h3);
    add_rec(2'd0, 4'hA, 16'o7577, 16'h1234, 16'h8765);
    add_rec(2'd0, 4'h5, 16'o7600, 16'hDEAD, 16'hBEEF);
    add_rec(2'd0, 4'hF, 16'o7677, 16'hCAFE, 16'hF00D);
    add_rec(2'd0, 4'h3, 16'o7700, 16'h0F0F, 16'hF0F0);
    run(16'h0010, 1'b0, 1'b1);

    // register file sweep over every bank
    nrec = 0;
    for (int i = 0; i < 16; i++)
      add_rec(2'd3, 4'd0, {8'h3C, 4'(i), 4'(15 - i)}, 16'hA000 + 16'(i * 7), 16'(i));
    run(16'h0083, 1'b1, 1'b1);

    // decode map sweep, upper target bits ignored, bad checksum
    nrec = 0;
    for (int i = 0; i < 8; i++)
      add_rec(2'd1, 4'd0, 16'hC000 | 16'((i % 4) << 8) | 16'((i * 37) % 256),
              16'h7700 + 16'(i), 16'h0077 * 16'(i + 1));
    run(16'h0000, 1'b1, 1'b0);

    // mixed list in replacement mode with one reserved-page record
    nrec = 0;
    for (int i = 0; i < 9; i++) begin
      logic [1:0] k = (i % 3 == 0) ? 2'd0 : (i % 3 == 1) ? 2'd1 : 2'd3;
      add_rec(k, 4'(i), (i == 3) ? 16'o7640 : 16'(i * 'h123), 16'(i * 'h2222), 16'hFFFF - 16'(i));
    end
    run(16'h0040, 1'b0, 1'b1);

    // list holding only the end record
    nrec = 0;
    run(16'h00F0, 1'b1, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule